// File: doc/BRIEF.md
# Scaled Base-Offset Address Generator

This block forms the 16-bit byte address of a load or store operand from a base-register choice, a short unsigned offset, an operand size and an addressing mode. It keeps its own copies of the four programmable base registers and of the index register. Each copy is loaded through a simple write port. A fifth base choice is wired to zero, so that choice reaches the bottom of the virtual store.

The offset is scaled by the operand size before it is added to the base. In indexed mode the scaled index is also added to that sum. In indirect mode the sum is sent out as a memory read over a valid/ready request channel. The 16-bit word that comes back is taken as a pointer, and the scaled index is added to it. The result is presented with a one-cycle done strobe. A base/mode/size combination outside the legal set raises an error pulse and produces no other activity.

Top module: `scaled_agen`

## Requirements
- R1: After reset, `req_ready` is 1 and `ea_done`, `fmt_err` and `mem_rd_valid` are 0. All held registers read as zero.
- R2: `req_base` codes: 0 selects a constant zero base, 1 selects the code-sequence base, 2 the workspace base, 3 the first data base and 4 the second data base. `wr_sel` codes: 0 loads the code-sequence base, 1 the workspace base, 2 the first data base, 3 the second data base and 4 the index register. Other `wr_sel` codes change nothing.
- R3: `req_offw` picks how many low bits of `req_off` are used: 0 keeps 4 bits, 1 keeps 5, 2 keeps 6 and 3 keeps all 8. The bits above that width are ignored.
- R4: `req_size` 0 (byte) scales by 1, 1 (half-word) by 2 and 2 (full-word) by 4. The offset and the index are both scaled. All sums wrap modulo 65536.
- R5: In `req_mode` 0 (direct), `ea_addr` equals base plus the scaled offset. `ea_done` rises in the cycle after acceptance and lasts exactly one cycle.
- R6: In `req_mode` 2 (indexed), `ea_addr` equals base plus the scaled offset plus the scaled index. Timing is the same as in R5.
- R7: In `req_mode` 1 (indirect), `mem_rd_valid` rises in the cycle after acceptance with `mem_rd_addr` equal to base plus the scaled offset. Both stay unchanged until `mem_rd_ready` is seen. The returned `mem_rsp_data` plus the scaled index becomes `ea_addr`, and `ea_done` pulses two cycles after `mem_rsp_valid` is sampled.
- R8: A request with `req_base` above 4, `req_mode` 3, `req_size` 3, or base 1 with mode 2 is illegal. It causes a one-cycle `fmt_err` pulse in the cycle after acceptance, and no `ea_done` and no memory read follow.
- R9: A request uses the register values held before its accepting edge. A write in the same cycle, or while the request is in flight, does not change that request's result.
- R10: `req_ready` is 1 only while no request is in progress. Each indirect request issues exactly one memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register chosen for the write |
| wr_data | input | 16 | Value written |
| req_valid | input | 1 | Address request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_base | input | 3 | Base selector code |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 indexed |
| req_size | input | 2 | Operand size code |
| req_off | input | 8 | Raw offset field |
| req_offw | input | 2 | Offset width code |
| mem_rd_valid | output | 1 | Pointer read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 16 | Byte address of the pointer word |
| mem_rsp_valid | input | 1 | Pointer data present |
| mem_rsp_data | input | 16 | Fetched pointer word |
| ea_addr | output | 16 | Final effective byte address |
| ea_done | output | 1 | One-cycle completion strobe |
| fmt_err | output | 1 | One-cycle illegal-format strobe |

## Verification
The assertions assume a well-behaved memory side. `mem_rsp_valid` arrives only once, and only after the read handshake has completed. Request fields are looked at only while `req_valid` and `req_ready` are both high. The bench keeps within these limits because it plays the memory itself. It raises `mem_rd_ready` only while a read is pending, returns exactly one response per read after a random delay, and offers a new request only after the previous one has finished.

// File: rtl/agen_pkg.sv
package agen_pkg;

  localparam int ADDR_W  = 16;
  localparam int OFF_W   = 8;
  localparam int NREG    = 5;
  localparam int SEL_W   = 3;

  typedef enum logic [1:0] {
    MD_DIRECT   = 2'd0,
    MD_INDIRECT = 2'd1,
    MD_INDEXED  = 2'd2,
    MD_BAD      = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    BS_ZERO = 3'd0,
    BS_SEQ  = 3'd1,
    BS_WSP  = 3'd2,
    BS_D1   = 3'd3,
    BS_D2   = 3'd4
  } base_e;

  localparam int IDX_SLOT = 4;

  // Shift a value left by the size code (0,1,2), wrapping at ADDR_W bits.
  function automatic logic [ADDR_W-1:0] size_scale(input logic [ADDR_W-1:0] v,
                                                   input logic [1:0] sz);
    size_scale = v << sz;
  endfunction

  // Keep only the offset bits chosen by the width code.
  function automatic logic [OFF_W-1:0] off_trim(input logic [OFF_W-1:0] off,
                                                input logic [1:0] wcode);
    int unsigned keep;
    logic [OFF_W-1:0] msk;
    keep = (wcode == 2'd3) ? OFF_W : 4 + int'(wcode);
    msk  = '0;
    for (int i = 0; i < OFF_W; i++) msk[i] = (i < int'(keep));
    off_trim = off & msk;
  endfunction

  function automatic logic fmt_legal(input logic [2:0] b, input logic [1:0] m,
                                     input logic [1:0] sz);
    fmt_legal = (b <= 3'(BS_D2)) && (m != 2'(MD_BAD)) && (sz != 2'd3)
                && !((b == 3'(BS_SEQ)) && (m == 2'(MD_INDEXED)));
  endfunction

endpackage

// File: rtl/agen_regfile.sv
module agen_regfile
  import agen_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NR = NREG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [AW-1:0]         wr_data,
  output logic [NR-1:0][AW-1:0] rd_val
);

  for (genvar g = 0; g < NR; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rd_val[g] <= '0;
      else if (hit) rd_val[g] <= wr_data;
    end
  end

endmodule

// File: rtl/agen_calc.sv
module agen_calc
  import agen_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W,
  parameter int NR = NREG
) (
  input  logic [NR-1:0][AW-1:0] regs,
  input  logic [2:0]            base_sel,
  input  logic [1:0]            mode,
  input  logic [1:0]            size,
  input  logic [OW-1:0]         off,
  input  logic [1:0]            offw,
  output logic                  legal,
  output logic                  is_ind,
  output logic [AW-1:0]         ptr_addr,
  output logic [AW-1:0]         fast_addr,
  output logic [AW-1:0]         x_scaled
);

  logic [AW-1:0] base_val;
  logic [AW-1:0] off_scaled;

  always_comb begin
    base_val = '0;
    for (int i = 1; i <= 4; i++)
      if (base_sel == 3'(i)) base_val = regs[i-1];
  end

  assign off_scaled = size_scale(AW'(off_trim(off, offw)), size);
  assign x_scaled   = size_scale(regs[IDX_SLOT], size);
  assign ptr_addr   = base_val + off_scaled;
  assign fast_addr  = (mode == 2'(MD_INDEXED)) ? ptr_addr + x_scaled : ptr_addr;
  assign legal      = fmt_legal(base_sel, mode, size);
  assign is_ind     = (mode == 2'(MD_INDIRECT));

endmodule

// File: rtl/agen_seq.sv
module agen_seq
  import agen_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          legal,
  input  logic          is_ind,
  input  logic [AW-1:0] ptr_addr,
  input  logic [AW-1:0] fast_addr,
  input  logic [AW-1:0] x_scaled,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic [AW-1:0] ea_addr,
  output logic          ea_done,
  output logic          fmt_err,
  output logic          acc_fast,
  output logic          acc_ind,
  output logic          acc_bad
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH_REQ, ST_FETCH_RSP, ST_ADD, ST_DONE
  } st_e;

  st_e           st_q;
  logic [AW-1:0] ptr_q, sx_q, ea_q;
  logic          err_q;
  logic          accept;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign acc_bad   = accept && !legal;
  assign acc_ind   = accept && legal && is_ind;
  assign acc_fast  = accept && legal && !is_ind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      sx_q  <= '0;
      ea_q  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= acc_bad;
      unique case (st_q)
        ST_IDLE: begin
          if (acc_fast) begin
            ea_q <= fast_addr;
            st_q <= ST_DONE;
          end else if (acc_ind) begin
            ptr_q <= ptr_addr;
            sx_q  <= x_scaled;
            st_q  <= ST_FETCH_REQ;
          end
        end
        ST_FETCH_REQ: if (mem_rd_ready) st_q <= ST_FETCH_RSP;
        ST_FETCH_RSP: if (mem_rsp_valid) begin
          ptr_q <= mem_rsp_data;
          st_q  <= ST_ADD;
        end
        ST_ADD: begin
          ea_q <= ptr_q + sx_q;
          st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_valid = (st_q == ST_FETCH_REQ);
  assign mem_rd_addr  = ptr_q;
  assign ea_addr      = ea_q;
  assign ea_done      = (st_q == ST_DONE);
  assign fmt_err      = err_q;

endmodule

// File: rtl/scaled_agen.sv
module scaled_agen
  import agen_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_base,
  input  logic [1:0]    req_mode,
  input  logic [1:0]    req_size,
  input  logic [OW-1:0] req_off,
  input  logic [1:0]    req_offw,
  output logic          mem_rd_valid,
  input  logic          mem_rd_ready,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic [AW-1:0] ea_addr,
  output logic          ea_done,
  output logic          fmt_err
);

  logic [NREG-1:0][AW-1:0] regs;
  logic          legal, is_ind;
  logic [AW-1:0] ptr_addr, fast_addr, x_scaled;
  logic          acc_fast, acc_ind, acc_bad;

  agen_regfile #(.AW(AW), .NR(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_val(regs)
  );

  agen_calc #(.AW(AW), .OW(OW), .NR(NREG)) u_calc (
    .regs(regs), .base_sel(req_base), .mode(req_mode), .size(req_size),
    .off(req_off), .offw(req_offw), .legal(legal), .is_ind(is_ind),
    .ptr_addr(ptr_addr), .fast_addr(fast_addr), .x_scaled(x_scaled)
  );

  agen_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .legal(legal), .is_ind(is_ind), .ptr_addr(ptr_addr),
    .fast_addr(fast_addr), .x_scaled(x_scaled),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .ea_addr(ea_addr), .ea_done(ea_done),
    .fmt_err(fmt_err), .acc_fast(acc_fast), .acc_ind(acc_ind),
    .acc_bad(acc_bad)
  );

endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_rd_valid,
  input logic          mem_rd_ready,
  input logic [AW-1:0] mem_rd_addr,
  input logic          ea_done,
  input logic          fmt_err,
  input logic          acc_fast,
  input logic          acc_ind,
  input logic          acc_bad
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ea_done |=> !ea_done);  // R5
  AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fast |=> ea_done);  // R6
  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> fmt_err && !ea_done && !mem_rd_valid);  // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));  // R7
  AST_IND_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ind |=> mem_rd_valid);  // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || ea_done) |-> !req_ready);  // R10
  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ea_done, fmt_err, mem_rd_valid}));  // R8

endmodule

bind scaled_agen agen_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .ea_done(ea_done), .fmt_err(fmt_err),
  .acc_fast(acc_fast), .acc_ind(acc_ind), .acc_bad(acc_bad)
);

// File: tb/scaled_agen_bench.sv
`timescale 1ns/1ps
module scaled_agen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_base = '0;
  logic [1:0]  req_mode = '0;
  logic [1:0]  req_size = '0;
  logic [7:0]  req_off = '0;
  logic [1:0]  req_offw = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [15:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic [15:0] ea_addr;
  logic        ea_done;
  logic        fmt_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] mreg [5];

  always #4 clk = ~clk;  // 125 MHz

  scaled_agen u_scaled_agen (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mult_of(input logic [1:0] sz);
    case (sz)
      2'd0: return 16'd1;
      2'd1: return 16'd2;
      default: return 16'd4;
    endcase
  endfunction

  function automatic logic [15:0] trim(input logic [7:0] o, input logic [1:0] w);
    case (w)
      2'd0: return {8'h0, o % 8'd16};
      2'd1: return {8'h0, o % 8'd32};
      2'd2: return {8'h0, o % 8'd64};
      default: return {8'h0, o};
    endcase
  endfunction

  function automatic logic [15:0] base_of(input logic [2:0] b);
    return (b == 3'd0) ? 16'h0 : mreg[b - 3'd1];
  endfunction

  function automatic bit ok_fmt(input logic [2:0] b, input logic [1:0] m,
                                input logic [1:0] sz);
    if (b > 3'd4 || m == 2'd3 || sz == 2'd3) return 0;
    if (b == 3'd1 && m == 2'd2) return 0;
    return 1;
  endfunction

  task automatic wreg(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = v;
    @(negedge clk);
    wr_en = 0;
    if (s <= 3'd4) mreg[s] = v;
  endtask

  // One request with bench-side memory; optional write in the accept cycle
  // (wsame) and optional index write while the pointer read is pending (wmid).
  task automatic do_req(input logic [2:0] b, input logic [1:0] m,
                        input logic [1:0] sz, input logic [7:0] off,
                        input logic [1:0] ow, input logic [15:0] pdata,
                        input int d1, input int d2,
                        input bit wsame, input logic [2:0] wsel,
                        input logic [15:0] wval, input bit wmid,
                        input logic [15:0] xmid, input string rq);
    logic [15:0] mul, soff, sx, pa, exp;
    int nrd;
    mul  = mult_of(sz);
    soff = trim(off, ow) * mul;
    sx   = mreg[4] * mul;
    pa   = base_of(b) + soff;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready before request", {15'h0, req_ready}, 16'h1);
    req_valid = 1; req_base = b; req_mode = m; req_size = sz;
    req_off = off; req_offw = ow;
    if (wsame) begin wr_en = 1; wr_sel = wsel; wr_data = wval; end
    @(negedge clk);
    req_valid = 0; req_off = $urandom(); req_base = 3'($urandom());
    wr_en = 0;
    if (wsame && wsel <= 3'd4) mreg[wsel] = wval;
    if (!ok_fmt(b, m, sz)) begin
      chk(fmt_err && !ea_done && !mem_rd_valid, {rq, " R8 error pulse"},
          {13'h0, fmt_err, ea_done, mem_rd_valid}, 16'h4);
      @(negedge clk);
      chk(!fmt_err && !ea_done && !mem_rd_valid, {rq, " R8 quiet after"},
          {13'h0, fmt_err, ea_done, mem_rd_valid}, 16'h0);
      return;
    end
    if (m != 2'd1) begin
      exp = (m == 2'd2) ? pa + sx : pa;
      chk(ea_done === 1'b1, {rq, " R5 done next cycle"}, {15'h0, ea_done}, 16'h1);
      chk(ea_addr === exp, {rq, (m == 2'd2) ? " R6 indexed address" : " R5 direct address"},
          ea_addr, exp);
      @(negedge clk);
      chk(ea_done === 1'b0, {rq, " R5 single pulse"}, {15'h0, ea_done}, 16'h0);
      return;
    end
    nrd = 0;
    chk(mem_rd_valid && mem_rd_addr == pa, {rq, " R7 pointer read addr"},
        mem_rd_addr, pa);
    chk(req_ready === 1'b0, {rq, " R10 busy"}, {15'h0, req_ready}, 16'h0);
    if (wmid) begin wreg(3'd4, xmid); end
    for (int i = 0; i < d1; i++) begin
      @(negedge clk);
      chk(mem_rd_valid && mem_rd_addr == pa, {rq, " R7 read held"}, mem_rd_addr, pa);
    end
    mem_rd_ready = 1;
    @(negedge clk);
    mem_rd_ready = 0;
    nrd++;
    for (int i = 0; i < d2; i++) begin
      @(negedge clk);
      if (mem_rd_valid) nrd++;
    end
    chk(nrd == 1, {rq, " R10 one read"}, 16'(nrd), 16'd1);
    mem_rsp_valid = 1; mem_rsp_data = pdata;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = $urandom();
    chk(ea_done === 1'b0, {rq, " R7 not yet done"}, {15'h0, ea_done}, 16'h0);
    @(negedge clk);
    exp = pdata + sx;
    chk(ea_done === 1'b1, {rq, " R7 done"}, {15'h0, ea_done}, 16'h1);
    chk(ea_addr === exp, {rq, " R7 indirect address"}, ea_addr, exp);
    @(negedge clk);
    chk(ea_done === 1'b0, {rq, " R5 single pulse"}, {15'h0, ea_done}, 16'h0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 5; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !ea_done && !fmt_err && !mem_rd_valid, "R1 outputs in reset",
        {12'h0, req_ready, ea_done, fmt_err, mem_rd_valid}, 16'h8);
    rst_n = 1;
    do_req(3'd4, 2'd0, 2'd0, 8'h00, 2'd3, 16'h0, 0, 0, 0, 0, 0, 0, 0, "R1 zero regs");

    // R2 register map
    wreg(3'd0, 16'h1000); wreg(3'd1, 16'h2000); wreg(3'd2, 16'h3000);
    wreg(3'd3, 16'h4000); wreg(3'd4, 16'h0003);
    wreg(3'd6, 16'hDEAD);
    for (int b = 0; b < 5; b++)
      do_req(3'(b), 2'd0, 2'd0, 8'h01, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 base select");
    do_req(3'd2, 2'd2, 2'd0, 8'h00, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 index slot");

    // R3 offset width codes, upper bits ignored
    for (int w = 0; w < 4; w++)
      do_req(3'd0, 2'd0, 2'd0, 8'hFF, 2'(w), 0, 0, 0, 0, 0, 0, 0, 0, "R3 width");

    // R4 scaling and wraparound
    wreg(3'd3, 16'hFFF0); wreg(3'd4, 16'h7FFF);
    for (int s = 0; s < 3; s++)
      do_req(3'd4, 2'd2, 2'(s), 8'hFF, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, "R4 scale wrap");

    // R6 indexed, R7 indirect with delays
    do_req(3'd3, 2'd2, 2'd1, 8'h05, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, "R6 indexed");
    do_req(3'd1, 2'd1, 2'd2, 8'h0A, 2'd2, 16'hBEE0, 3, 2, 0, 0, 0, 0, 0, "R7 indirect");
    do_req(3'd0, 2'd1, 2'd0, 8'h07, 2'd0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, "R7 fast mem");

    // R8 illegal formats
    do_req(3'd1, 2'd2, 2'd0, 8'h01, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 seq indexed");
    do_req(3'd5, 2'd0, 2'd0, 8'h01, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 base code");
    do_req(3'd2, 2'd3, 2'd0, 8'h01, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 mode code");
    do_req(3'd2, 2'd0, 2'd3, 8'h01, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 size code");

    // R9 snapshot: same-cycle write and in-flight index write
    do_req(3'd3, 2'd0, 2'd0, 8'h02, 2'd0, 0, 0, 0, 1, 3'd2, 16'h5555, 0, 0, "R9 same cycle");
    do_req(3'd3, 2'd0, 2'd0, 8'h02, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 after write");
    do_req(3'd2, 2'd1, 2'd1, 8'h03, 2'd0, 16'h0100, 2, 1, 0, 0, 0, 1, 16'h0040, "R9 in flight");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) == 0) wreg(3'($urandom_range(0, 4)), 16'($urandom()));
      do_req(($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4)),
             ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2)),
             ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2)),
             8'($urandom()), 2'($urandom()), 16'($urandom()),
             $urandom_range(0, 3), $urandom_range(0, 3),
             ($urandom_range(0, 5) == 0), 3'($urandom_range(0, 4)), 16'($urandom()),
             ($urandom_range(0, 5) == 0), 16'($urandom()), "random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule